// File: doc/BRIEF.md
# Protection Fault and Hiccup Controller

This block supervises a step-down converter controller against three fault classes: undervoltage (on either the bias supply or the conversion input), over-temperature and output short circuit. It receives digitized samples of the bias supply and of the input-enable divider in millivolts, a die-temperature sample in degrees Celsius and a short-circuit comparator flag. While any fault is active it holds the regulator idle: the gate drivers are disabled and both the soft-start node and the compensation node are clamped low.

Each class follows its own restart policy. An undervoltage idle ends as soon as the supply conditions recover, without any timer. A short circuit or thermal fault starts a retry timer counted in pulses of the `tick_i` time base. A short retries as soon as that timer ends. A thermal fault keeps re-arming the timer until the temperature has cleared. A restart happens only when every fault source is clear, and it is marked by a one-cycle strobe. A status word records which class caused the latest entry into idle.

Top module: `fault_hiccup_ctrl`

## Requirements
- R1: While `rst_ni` is low, `drv_off_o`, `ss_clamp_o` and `comp_clamp_o` are 1, `restart_o` is 0 and `status_o` is 1 (undervoltage).
- R2: `vbias_i` (unsigned mV) counts as good once it is at least 4250 and as undervoltage once it is below 4050. Between those values the previous state is kept. After reset it starts as undervoltage.
- R3: `vin_uv_i` (unsigned mV) counts as good once it is above 2500 and as undervoltage once it is below 2200. Between those values the previous state is kept. After reset it starts as undervoltage.
- R4: `temp_i` (unsigned °C) counts as hot once it is at least 145 and as cleared once it is at most 135. Between those values the previous state is kept.
- R5: `short_i` high is a short-circuit fault.
- R6: `drv_off_o`, `ss_clamp_o` and `comp_clamp_o` are always equal: 1 in idle and 0 while running.
- R7: An undervoltage idle is left as soon as both supplies are good, with no timer, provided that no other fault is present.
- R8: A short-circuit idle lasts exactly `HICCUP_TICKS` tick pulses. The block restarts at the tick that ends this period if no fault is then present. If a fault is present, the period re-arms.
- R9: A thermal idle re-arms the timer at each expiry while hot. It restarts only at the first expiry after the temperature has cleared.
- R10: `status_o` encoding: 1 = undervoltage, 2 = thermal, 3 = short. On entry to idle the class is chosen with the priority undervoltage > thermal > short. Undervoltage arising during a timed idle moves the block to an undervoltage idle. `status_o` does not change while running.
- R11: `restart_o` is a single-cycle pulse, asserted in the first running cycle after idle.
- R12: An input sampled at clock edge k that causes a fault puts the block in idle after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base pulse for the retry timer |
| vbias_i | input | VW | Bias supply sample, mV |
| vin_uv_i | input | VW | Input-enable divider sample, mV |
| temp_i | input | TW | Die temperature, °C |
| short_i | input | 1 | Short-circuit comparator flag |
| drv_off_o | output | 1 | Gate drivers held off |
| ss_clamp_o | output | 1 | Soft-start node pulled low |
| comp_clamp_o | output | 1 | Compensation node pulled low |
| restart_o | output | 1 | One-cycle restart strobe |
| status_o | output | 2 | Class of the latest idle entry |

## Verification
Every input is first registered in a qualification stage and then acted on by the state register. A fault sampled at edge k therefore shows on the clamps after edge k+1, and a clearance returns the block to run after edge k+1, with `restart_o` high in that same cycle. For a timed idle, the release comes at the edge that sees the `HICCUP_TICKS`-th tick counted from the cycle after entry. The bench keeps a cycle model of these rules that it advances at each rising edge. It compares all outputs at the falling edge. Its directed checks step whole cycles by these exact counts before sampling.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_UV    = 2'd1,
    CLS_THERM = 2'd2,
    CLS_SHORT = 2'd3
  } fault_cls_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_UVWAIT = 2'd1,
    ST_HICCUP = 2'd2
  } sup_state_e;
endpackage

// File: rtl/fhc_hyst_cmp.sv
module fhc_hyst_cmp #(
  parameter int unsigned W      = 13,
  parameter int unsigned SET_TH = 100,
  parameter int unsigned CLR_TH = 90,
  parameter bit          RST_V  = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] x_i,
  output logic         flag_o
);
  localparam logic [W-1:0] SET_C = W'(SET_TH);
  localparam logic [W-1:0] CLR_C = W'(CLR_TH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_o <= RST_V;
    else if (x_i >= SET_C)  flag_o <= 1'b1;
    else if (x_i <  CLR_C)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/fhc_hiccup_timer.sv
module fhc_hiccup_timer #(
  parameter int unsigned TICKS = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned   CW   = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/fhc_fsm.sv
module fhc_fsm
  import fhc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_i,
  input  logic       hot_i,
  input  logic       sc_i,
  input  logic       expire_i,
  output logic       idle_o,
  output logic       tmr_clr_o,
  output logic       tmr_run_o,
  output logic       restart_o,
  output logic [1:0] status_o
);
  sup_state_e state_q, state_d;
  fault_cls_e cls_q, cls_d;
  logic       rs_q, rs_d;

  always_comb begin
    state_d   = state_q;
    cls_d     = cls_q;
    tmr_clr_o = 1'b0;
    rs_d      = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (uv_i) begin
          state_d = ST_UVWAIT; cls_d = CLS_UV;
        end else if (hot_i) begin
          state_d = ST_HICCUP; cls_d = CLS_THERM; tmr_clr_o = 1'b1;
        end else if (sc_i) begin
          state_d = ST_HICCUP; cls_d = CLS_SHORT; tmr_clr_o = 1'b1;
        end
      end
      ST_UVWAIT: begin
        if (!uv_i) begin
          if (hot_i) begin
            state_d = ST_HICCUP; cls_d = CLS_THERM; tmr_clr_o = 1'b1;
          end else if (sc_i) begin
            state_d = ST_HICCUP; cls_d = CLS_SHORT; tmr_clr_o = 1'b1;
          end else begin
            state_d = ST_RUN; rs_d = 1'b1;
          end
        end
      end
      ST_HICCUP: begin
        if (uv_i) begin
          state_d = ST_UVWAIT; cls_d = CLS_UV;
        end else if (expire_i) begin
          if (hot_i || sc_i) tmr_clr_o = 1'b1;  // re-arm
          else begin
            state_d = ST_RUN; rs_d = 1'b1;
          end
        end
      end
      default: state_d = ST_UVWAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UVWAIT;
      cls_q   <= CLS_UV;
      rs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cls_q   <= cls_d;
      rs_q    <= rs_d;
    end
  end

  assign idle_o    = (state_q != ST_RUN);
  assign tmr_run_o = (state_q == ST_HICCUP);
  assign restart_o = rs_q;
  assign status_o  = cls_q;
endmodule

// File: rtl/fault_hiccup_ctrl.sv
module fault_hiccup_ctrl #(
  parameter int unsigned VW           = 13,
  parameter int unsigned TW           = 8,
  parameter int unsigned VB_ON        = 4250,
  parameter int unsigned VB_HYS       = 200,
  parameter int unsigned VI_ON        = 2500,
  parameter int unsigned VI_HYS       = 300,
  parameter int unsigned T_TRIP       = 145,
  parameter int unsigned T_HYS        = 10,
  parameter int unsigned HICCUP_TICKS = 200000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [VW-1:0] vbias_i,
  input  logic [VW-1:0] vin_uv_i,
  input  logic [TW-1:0] temp_i,
  input  logic          short_i,
  output logic          drv_off_o,
  output logic          ss_clamp_o,
  output logic          comp_clamp_o,
  output logic          restart_o,
  output logic [1:0]    status_o
);
  localparam int unsigned VB_CLR = VB_ON - VB_HYS;
  localparam int unsigned VI_SET = VI_ON + 1;      // strictly above
  localparam int unsigned VI_CLR = VI_ON - VI_HYS;
  localparam int unsigned T_CLR  = T_TRIP - T_HYS + 1; // clear at <= trip-hys

  logic vb_ok, vi_ok, hot, sc_q, expire, idle, tmr_clr, tmr_run;

  fhc_hyst_cmp #(.W(VW), .SET_TH(VB_ON), .CLR_TH(VB_CLR), .RST_V(1'b0)) u_vb (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(vbias_i), .flag_o(vb_ok));

  fhc_hyst_cmp #(.W(VW), .SET_TH(VI_SET), .CLR_TH(VI_CLR), .RST_V(1'b0)) u_vi (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(vin_uv_i), .flag_o(vi_ok));

  fhc_hyst_cmp #(.W(TW), .SET_TH(T_TRIP), .CLR_TH(T_CLR), .RST_V(1'b0)) u_tmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(temp_i), .flag_o(hot));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sc_q <= 1'b0;
    else         sc_q <= short_i;
  end

  fhc_hiccup_timer #(.TICKS(HICCUP_TICKS)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .run_i(tmr_run),
    .tick_i(tick_i), .expire_o(expire));

  fhc_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .uv_i(!vb_ok || !vi_ok), .hot_i(hot),
    .sc_i(sc_q), .expire_i(expire), .idle_o(idle), .tmr_clr_o(tmr_clr),
    .tmr_run_o(tmr_run), .restart_o(restart_o), .status_o(status_o));

  assign drv_off_o    = idle;
  assign ss_clamp_o   = idle;
  assign comp_clamp_o = idle;
endmodule

// File: rtl/fhc_checker.sv
module fhc_checker #(
  parameter int unsigned VW     = 13,
  parameter int unsigned TW     = 8,
  parameter int unsigned VB_ON  = 4250,
  parameter int unsigned VB_HYS = 200,
  parameter int unsigned VI_ON  = 2500,
  parameter int unsigned VI_HYS = 300,
  parameter int unsigned T_TRIP = 145
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [VW-1:0] vbias_i,
  input logic [VW-1:0] vin_uv_i,
  input logic [TW-1:0] temp_i,
  input logic          short_i,
  input logic          drv_off_o,
  input logic          ss_clamp_o,
  input logic          comp_clamp_o,
  input logic          restart_o,
  input logic [1:0]    status_o
);
  localparam logic [VW-1:0] VB_LO = VW'(VB_ON - VB_HYS);
  localparam logic [VW-1:0] VI_LO = VW'(VI_ON - VI_HYS);
  localparam logic [TW-1:0] T_HI  = TW'(T_TRIP);

  AST_IDLE_CLAMPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_clamp_o == drv_off_o) && (comp_clamp_o == drv_off_o)); // R6

  AST_RESTART_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o); // R11

  AST_RESTART_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (!drv_off_o && $past(drv_off_o))); // R11

  AST_BIAS_UV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vbias_i < VB_LO, 2) |-> drv_off_o); // R2

  AST_VIN_UV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vin_uv_i < VI_LO, 2) |-> drv_off_o); // R3

  AST_HOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(temp_i >= T_HI, 2) |-> drv_off_o); // R4

  AST_SHORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(short_i, 2) |-> drv_off_o); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_off_o && $past(!drv_off_o)) |-> $stable(status_o)); // R10
endmodule

bind fault_hiccup_ctrl fhc_checker #(
  .VW(VW), .TW(TW), .VB_ON(VB_ON), .VB_HYS(VB_HYS),
  .VI_ON(VI_ON), .VI_HYS(VI_HYS), .T_TRIP(T_TRIP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vbias_i(vbias_i), .vin_uv_i(vin_uv_i),
  .temp_i(temp_i), .short_i(short_i), .drv_off_o(drv_off_o),
  .ss_clamp_o(ss_clamp_o), .comp_clamp_o(comp_clamp_o),
  .restart_o(restart_o), .status_o(status_o));

// File: tb/fault_hiccup_ctrl_test.sv
module fault_hiccup_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int VW = 13;
  localparam int TW = 8;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, short_i = 1'b0;
  logic [VW-1:0] vbias_i = 13'd5000, vin_uv_i = 13'd3000;
  logic [TW-1:0] temp_i = 8'd25;
  logic drv_off_o, ss_clamp_o, comp_clamp_o, restart_o;
  logic [1:0] status_o;

  int checks = 0, fails = 0;
  bit done = 0, tick_all = 1, model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_hiccup_ctrl #(.VW(VW), .TW(TW), .HICCUP_TICKS(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .vbias_i(vbias_i),
    .vin_uv_i(vin_uv_i), .temp_i(temp_i), .short_i(short_i),
    .drv_off_o(drv_off_o), .ss_clamp_o(ss_clamp_o), .comp_clamp_o(comp_clamp_o),
    .restart_o(restart_o), .status_o(status_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(int vb, int vi, int t, bit s);
    vbias_i = VW'(vb); vin_uv_i = VW'(vi); temp_i = TW'(t); short_i = s;
  endtask

  always @(negedge clk) tick_i <= tick_all ? 1'b1 : ($urandom % 3 == 0);

  // Cycle model derived from the requirements: 0 run, 1 uv wait, 2 timed idle
  int m_st, m_cnt, m_stat, n_st, n_stat;
  bit m_bok, m_vok, m_hot, m_sc, m_rs, n_rs, m_clr, m_exp, m_uv;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_bok = 0; m_vok = 0; m_hot = 0; m_sc = 0;
      m_st = 1; m_cnt = 0; m_stat = 1; m_rs = 0;
    end else begin
      m_uv  = !m_bok || !m_vok;
      m_exp = (m_st == 2) && tick_i && (m_cnt == N-1);
      n_st = m_st; n_stat = m_stat; n_rs = 0; m_clr = 0;
      if (m_st == 0) begin
        if (m_uv) begin n_st = 1; n_stat = 1; end
        else if (m_hot) begin n_st = 2; n_stat = 2; m_clr = 1; end
        else if (m_sc) begin n_st = 2; n_stat = 3; m_clr = 1; end
      end else if (m_st == 1) begin
        if (!m_uv) begin
          if (m_hot) begin n_st = 2; n_stat = 2; m_clr = 1; end
          else if (m_sc) begin n_st = 2; n_stat = 3; m_clr = 1; end
          else begin n_st = 0; n_rs = 1; end
        end
      end else begin
        if (m_uv) begin n_st = 1; n_stat = 1; end
        else if (m_exp) begin
          if (m_hot || m_sc) m_clr = 1;
          else begin n_st = 0; n_rs = 1; end
        end
      end
      if (m_clr) m_cnt = 0;
      else if (m_st == 2 && tick_i) m_cnt = m_exp ? 0 : m_cnt + 1;
      m_st = n_st; m_stat = n_stat; m_rs = n_rs;
      if (vbias_i >= 4250) m_bok = 1; else if (vbias_i < 4050) m_bok = 0;
      if (vin_uv_i > 2500) m_vok = 1; else if (vin_uv_i < 2200) m_vok = 0;
      if (temp_i >= 145) m_hot = 1; else if (temp_i <= 135) m_hot = 0;
      m_sc = short_i;
    end
  end

  always @(negedge clk) if (rst_ni && model_on) begin
    chk("R12 drv_off vs model", drv_off_o, m_st != 0);
    chk("R6 ss_clamp", ss_clamp_o, m_st != 0);
    chk("R6 comp_clamp", comp_clamp_o, m_st != 0);
    chk("R10 status", status_o, m_stat);
    chk("R11 restart", restart_o, m_rs);
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    chk("R1 drv_off", drv_off_o, 1); chk("R1 ss", ss_clamp_o, 1);
    chk("R1 comp", comp_clamp_o, 1); chk("R1 restart", restart_o, 0);
    chk("R1 status", status_o, 1);
    rst_ni = 1'b1; model_on = 1;
    step(2);
    chk("R7 start", drv_off_o, 0); chk("R11 strobe", restart_o, 1);
    step(1); chk("R11 single", restart_o, 0);
    // R2 bias thresholds
    set_in(4050, 3000, 25, 0); step(3); chk("R2 4050 holds", drv_off_o, 0);
    set_in(4049, 3000, 25, 0); step(1); chk("R12 not yet", drv_off_o, 0);
    step(1); chk("R2 4049 trips", drv_off_o, 1); chk("R10 uv", status_o, 1);
    set_in(4249, 3000, 25, 0); step(3); chk("R2 4249 held", drv_off_o, 1);
    set_in(4250, 3000, 25, 0); step(2); chk("R7 release", drv_off_o, 0);
    // R3 input thresholds
    set_in(5000, 2200, 25, 0); step(3); chk("R3 2200 holds", drv_off_o, 0);
    set_in(5000, 2199, 25, 0); step(2); chk("R3 2199 trips", drv_off_o, 1);
    set_in(5000, 2500, 25, 0); step(3); chk("R3 2500 held", drv_off_o, 1);
    set_in(5000, 2501, 25, 0); step(2); chk("R3 2501 release", drv_off_o, 0);
    // R4/R9 thermal
    set_in(5000, 3000, 144, 0); step(3); chk("R4 144 ok", drv_off_o, 0);
    set_in(5000, 3000, 145, 0); step(2); chk("R4 145 trips", drv_off_o, 1);
    chk("R10 thermal", status_o, 2);
    set_in(5000, 3000, 136, 0); step(3*N); chk("R9 rearm while hot", drv_off_o, 1);
    set_in(5000, 3000, 135, 0); step(N+3); chk("R9 restart after clear", drv_off_o, 0);
    chk("R10 status kept", status_o, 2);
    // R5/R8 short, exact period
    set_in(5000, 3000, 25, 1); step(1); short_i = 0;
    step(1); chk("R5 short idle", drv_off_o, 1); chk("R10 short", status_o, 3);
    step(N-1); chk("R8 still idle", drv_off_o, 1);
    step(1); chk("R8 restart at expiry", drv_off_o, 0); chk("R8 strobe", restart_o, 1);
    // R8 persistent short
    short_i = 1; step(3*N); chk("R8 blocked", drv_off_o, 1);
    short_i = 0; step(N+3); chk("R8 retry", drv_off_o, 0);
    // R10 priority
    set_in(4000, 3000, 150, 1); step(2); chk("R10 uv first", status_o, 1);
    set_in(5000, 3000, 150, 1); step(2); chk("R10 thermal next", status_o, 2);
    chk("R9 idle", drv_off_o, 1);
    set_in(5000, 3000, 100, 0); step(N+3); chk("R9 exit", drv_off_o, 0);
    // random phase
    tick_all = 0;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 32;
      vbias_i  = (r == 0) ? 13'd4000 : (r == 1) ? 13'd4100 : 13'd5000;
      r = $urandom % 32;
      vin_uv_i = (r == 0) ? 13'd2100 : (r == 1) ? 13'd2300 : 13'd3000;
      r = $urandom % 32;
      temp_i   = (r == 0) ? 8'd160 : (r == 1) ? 8'd140 : 8'd60;
      short_i  = ($urandom % 40 == 0);
      step(1 + $urandom % 8);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule